// File: doc/BRIEF.md
# Background Debug Command Engine

This block carries out commands for a processor's background debug mode. A serial front end deserializes each command into an opcode, a register selector, an operand size, an address and a data word. It presents them with a one-cycle valid strobe while the engine is not busy. The engine then does the work. It can access the register file through a simple port, run one cycle on a memory bus that carries a function code, pulse core control lines, or time a peripheral reset. It then returns a one-cycle response with a status bit and a data word.

Block transfers work in two steps. A READ or WRITE fixes the start address and operand size. Each following DUMP or FILL then steps that saved address forward by the operand size and accesses the next location. The peripheral reset command holds a reset output for a fixed number of cycles and leaves the core alone. While that count runs, every command is refused.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcodes on `cmd_op` are 0 NOP, 1 register read, 2 register write, 3 system register read, 4 system register write, 5 READ, 6 WRITE, 7 DUMP, 8 FILL, 9 GO, 10 CALL, 11 RST. A NOP answers with `rsp_illegal`=0 and `rsp_data`=0, and causes no memory or register access.
- R2: Register read and write use `rf_idx`=`cmd_reg`, where bit 3 set selects an address register, and `rf_sys`=0. A read returns `rf_rdata`. A write drives `cmd_data` on `rf_wdata` with `rf_we`=1.
- R3: System register read and write access the register port with `rf_sys`=1, and otherwise behave as in R2.
- R4: READ runs one bus read at `cmd_addr` with `mem_fc`=`sfc`. `cmd_size` is 0 for a byte, 1 for a word and 2 for a long word. The right-aligned result is zero-extended to 32 bits.
- R5: WRITE runs one bus write of `cmd_data` at `cmd_addr` with the given size and `mem_fc`=`dfc`.
- R6: A DUMP is legal only when the previous accepted command was a READ or a DUMP. It reads at the saved address plus the operand size (1, 2 or 4 bytes) of the originating READ, and that sum becomes the new saved address.
- R7: A FILL is legal only when the previous accepted command was a WRITE or a FILL. It writes `cmd_data` at the saved address plus the operand size of the originating WRITE.
- R8: The engine answers with `rsp_illegal`=1 and `rsp_data`=0, and runs no bus or register cycle, in these cases: an unchained DUMP or FILL, an opcode of 12 to 15, a READ or WRITE with size 3, or any command accepted while `periph_rst` is high.
- R9: RST holds `periph_rst` high for exactly RST_CYCLES (512) consecutive cycles. It does not touch `pipe_flush`, `pc_load` or `core_release`.
- R10: GO pulses `pipe_flush` for one cycle. It then pulses `core_release` in the following cycle, together with the response.
- R11: CALL writes `cur_pc` as a long word at `cur_sp` with `mem_fc`=`dfc`. It then pulses `pc_load` with `pc_value`=`cmd_addr`, and `core_release` at the same time.
- R12: `busy` is high from the cycle after a command is accepted until the cycle after `rsp_valid`. A `cmd_valid` strobe while `busy` is high is ignored. `rsp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_reg | input | 4 | Register selector |
| cmd_size | input | 2 | Operand size code |
| cmd_addr | input | 32 | Address or patch address |
| cmd_data | input | 32 | Write operand |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_illegal | output | 1 | Command refused |
| rsp_data | output | 32 | Result |
| rf_en | output | 1 | Register port access |
| rf_we | output | 1 | Register port write |
| rf_sys | output | 1 | System register select |
| rf_idx | output | 4 | Register index |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Register read data |
| sfc | input | 3 | Source function code |
| dfc | input | 3 | Destination function code |
| cur_pc | input | 32 | Current program counter |
| cur_sp | input | 32 | Current stack pointer |
| mem_req | output | 1 | Bus request, held until ack |
| mem_we | output | 1 | Bus write |
| mem_size | output | 2 | Bus size code |
| mem_fc | output | 3 | Bus function code |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 32 | Bus read data, right-aligned |
| pipe_flush | output | 1 | Pipeline flush pulse |
| core_release | output | 1 | Core resume pulse |
| pc_load | output | 1 | PC load pulse |
| pc_value | output | 32 | PC load value |
| periph_rst | output | 1 | Peripheral reset |

## Verification
The hardest case to reach is a strobe that arrives while a command is still in flight. To get there, the bench stretches the bus acknowledge by several cycles during a READ. It raises a register-write strobe inside that window and drops it again before the response. A later register read then shows that the write never took place. The refusal during the peripheral reset is set up in a similar way: commands are issued while the 512-cycle count runs, and a separate counter checks that the pulse length is unchanged.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RIW = 4,
  parameter int FCW = 3,
  parameter int RST_CYCLES = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [RIW-1:0] cmd_reg,
  input  logic [1:0]     cmd_size,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic           busy,
  output logic           rsp_valid,
  output logic           rsp_illegal,
  output logic [DW-1:0]  rsp_data,
  output logic           rf_en,
  output logic           rf_we,
  output logic           rf_sys,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata,
  input  logic [DW-1:0]  rf_rdata,
  input  logic [FCW-1:0] sfc,
  input  logic [FCW-1:0] dfc,
  input  logic [AW-1:0]  cur_pc,
  input  logic [AW-1:0]  cur_sp,
  output logic           mem_req,
  output logic           mem_we,
  output logic [1:0]     mem_size,
  output logic [FCW-1:0] mem_fc,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           pipe_flush,
  output logic           core_release,
  output logic           pc_load,
  output logic [AW-1:0]  pc_value,
  output logic           periph_rst
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [3:0] OP_NOP = 4'd0, OP_RREG = 4'd1, OP_WREG = 4'd2,
                         OP_RSYS = 4'd3, OP_WSYS = 4'd4, OP_READ = 4'd5,
                         OP_WRITE = 4'd6, OP_DUMP = 4'd7, OP_FILL = 4'd8,
                         OP_GO = 4'd9, OP_CALL = 4'd10, OP_RST = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_REG, S_MEM, S_FLUSH, S_RSP} st_t;

  st_t            state;
  logic [3:0]     op_q;
  logic [RIW-1:0] reg_q;
  logic [1:0]     size_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic           blocked_q;
  logic           ill_q;
  logic [DW-1:0]  res_q;
  logic [AW-1:0]  blk_addr;
  logic [1:0]     blk_size;
  logic           rd_chain, wr_chain;
  logic [CW-1:0]  rst_cnt;
  logic           mwe_q;
  logic [1:0]     msize_q;
  logic [FCW-1:0] mfc_q;
  logic [AW-1:0]  maddr_q;
  logic [DW-1:0]  mwdata_q;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = DW'(8'hFF);
      2'd1:    size_mask = DW'(16'hFFFF);
      default: size_mask = '1;
    endcase
  endfunction

  wire [AW-1:0] step     = AW'(1) << blk_size;
  wire [AW-1:0] blk_next = blk_addr + step;
  wire is_rw    = (op_q == OP_READ) || (op_q == OP_WRITE);
  wire is_block = (op_q == OP_DUMP) || (op_q == OP_FILL);
  wire is_reg   = (op_q == OP_RREG) || (op_q == OP_WREG) ||
                  (op_q == OP_RSYS) || (op_q == OP_WSYS);
  wire is_mem   = is_rw || is_block || (op_q == OP_CALL);
  wire illegal  = blocked_q || (op_q > OP_RST) ||
                  (is_rw && size_q == 2'd3) ||
                  (op_q == OP_DUMP && !rd_chain) ||
                  (op_q == OP_FILL && !wr_chain);

  assign busy        = state != S_IDLE;
  assign rsp_valid   = state == S_RSP;
  assign rsp_illegal = ill_q;
  assign rsp_data    = res_q;

  assign rf_en    = state == S_REG;
  assign rf_we    = (op_q == OP_WREG) || (op_q == OP_WSYS);
  assign rf_sys   = (op_q == OP_RSYS) || (op_q == OP_WSYS);
  assign rf_idx   = reg_q;
  assign rf_wdata = data_q;

  assign mem_req   = state == S_MEM;
  assign mem_we    = mwe_q;
  assign mem_size  = msize_q;
  assign mem_fc    = mfc_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;

  assign pipe_flush   = state == S_FLUSH;
  assign core_release = rsp_valid && !ill_q && (op_q == OP_GO || op_q == OP_CALL);
  assign pc_load      = rsp_valid && !ill_q && (op_q == OP_CALL);
  assign pc_value     = addr_q;
  assign periph_rst   = rst_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_NOP;
      reg_q     <= '0;
      size_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      blocked_q <= 1'b0;
      ill_q     <= 1'b0;
      res_q     <= '0;
      blk_addr  <= '0;
      blk_size  <= '0;
      rd_chain  <= 1'b0;
      wr_chain  <= 1'b0;
      mwe_q     <= 1'b0;
      msize_q   <= '0;
      mfc_q     <= '0;
      maddr_q   <= '0;
      mwdata_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q      <= cmd_op;
          reg_q     <= cmd_reg;
          size_q    <= cmd_size;
          addr_q    <= cmd_addr;
          data_q    <= cmd_data;
          blocked_q <= periph_rst;
          ill_q     <= 1'b0;
          res_q     <= '0;
          state     <= S_DEC;
        end
        S_DEC: begin
          rd_chain <= !illegal && (op_q == OP_READ || op_q == OP_DUMP);
          wr_chain <= !illegal && (op_q == OP_WRITE || op_q == OP_FILL);
          if (illegal) begin
            ill_q <= 1'b1;
            state <= S_RSP;
          end else begin
            mwe_q    <= (op_q == OP_WRITE) || (op_q == OP_FILL) || (op_q == OP_CALL);
            mfc_q    <= (op_q == OP_READ || op_q == OP_DUMP) ? sfc : dfc;
            mwdata_q <= (op_q == OP_CALL) ? DW'(cur_pc) : data_q;
            if (is_rw) begin
              blk_addr <= addr_q;
              blk_size <= size_q;
              maddr_q  <= addr_q;
              msize_q  <= size_q;
            end else if (is_block) begin
              blk_addr <= blk_next;
              maddr_q  <= blk_next;
              msize_q  <= blk_size;
            end else begin
              maddr_q  <= cur_sp;
              msize_q  <= 2'd2;
            end
            if (is_reg)                state <= S_REG;
            else if (is_mem)           state <= S_MEM;
            else if (op_q == OP_GO)    state <= S_FLUSH;
            else                       state <= S_RSP;
          end
        end
        S_REG: begin
          if (!rf_we) res_q <= rf_rdata;
          state <= S_RSP;
        end
        S_MEM: if (mem_ack) begin
          if (!mwe_q) res_q <= mem_rdata & size_mask(msize_q);
          state <= S_RSP;
        end
        S_FLUSH: state <= S_RSP;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_cnt <= '0;
    else if (state == S_DEC && op_q == OP_RST && !illegal)
      rst_cnt <= CW'(RST_CYCLES);
    else if (rst_cnt != '0)
      rst_cnt <= rst_cnt - 1'b1;
  end

  a_r12_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  a_r12_accept_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  a_r12_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, rf_en, pipe_flush, rsp_valid}));
  a_r8_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && illegal) |=> !mem_req && !rf_en && !pipe_flush);
  a_r4_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_fc)
                              && $stable(mem_we) && $stable(mem_size));
  a_r9_rst_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst) |-> $past(state == S_DEC));
  a_r9_core_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> !pipe_flush && !pc_load && !core_release);
  a_r10_release_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> core_release && rsp_valid);

endmodule

// File: tb/sim_dbg_cmd_engine.sv
module sim_dbg_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0, cmd_reg = '0;
  logic [1:0] cmd_size = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic busy, rsp_valid, rsp_illegal;
  logic [31:0] rsp_data;
  logic rf_en, rf_we, rf_sys;
  logic [3:0] rf_idx;
  logic [31:0] rf_wdata, rf_rdata;
  logic [2:0] sfc = 3'd5, dfc = 3'd1;
  logic [31:0] cur_pc = 32'h0000_4242, cur_sp = 32'h0000_00C0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0] mem_size;
  logic [2:0] mem_fc;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic pipe_flush, core_release, pc_load, periph_rst;
  logic [31:0] pc_value;

  dbg_cmd_engine u0 (.*);

  logic [7:0] mem [0:255];
  logic [31:0] dreg [0:15];
  logic [31:0] sreg [0:15];
  int dly = 0, wcnt = 0;
  int cyc = 0, mem_cnt = 0, rf_cnt = 0, flush_cyc = -1, rel_cyc = -1, rel_cnt = 0;
  int pcl_cnt = 0, rst_hi = 0, core_during_rst = 0;
  logic [31:0] last_addr = '0, last_wdata = '0, pcl_val = '0;
  logic [2:0] last_fc = '0;
  logic last_we = 1'b0;
  logic [1:0] last_size = '0;
  int vecs = 0, fails = 0;
  logic r_ill;
  logic [31:0] r_data;

  function automatic logic [7:0] pat(input int i);
    return 8'((i % 256) * 37 + 11);
  endfunction

  function automatic logic [31:0] pat_word(input int a, input int s);
    logic [31:0] v = '0;
    for (int b = 0; b < (1 << s); b++) v = (v << 8) | 32'(pat(a + b));
    return v;
  endfunction

  function automatic logic [31:0] bus_read(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] v = 32'hA5A5_A5A5;
    int n = 1 << s;
    for (int b = 0; b < n; b++) v[8*(n-1-b) +: 8] = mem[8'(a[7:0] + 8'(b))];
    return v;
  endfunction

  assign mem_rdata = bus_read(mem_addr, mem_size);
  assign rf_rdata  = rf_sys ? sreg[rf_idx] : dreg[rf_idx];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    for (int i = 0; i < 16; i++) begin
      dreg[i] = 32'h1000_0000 + 32'(i) * 32'h111;
      sreg[i] = 32'h5000_0000 | 32'(i);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      if (wcnt >= dly) begin mem_ack <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else mem_ack <= 1'b0;
    if (mem_req && mem_ack) begin
      mem_cnt <= mem_cnt + 1;
      last_addr <= mem_addr; last_fc <= mem_fc; last_we <= mem_we;
      last_size <= mem_size; last_wdata <= mem_wdata;
      if (mem_we)
        for (int b = 0; b < (1 << mem_size); b++)
          mem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*((1 << mem_size)-1-b) +: 8];
    end
    if (rf_en) begin
      rf_cnt <= rf_cnt + 1;
      if (rf_we) begin
        if (rf_sys) sreg[rf_idx] <= rf_wdata;
        else dreg[rf_idx] <= rf_wdata;
      end
    end
    if (pipe_flush) flush_cyc <= cyc;
    if (core_release) begin rel_cyc <= cyc; rel_cnt <= rel_cnt + 1; end
    if (pc_load) begin pcl_cnt <= pcl_cnt + 1; pcl_val <= pc_value; end
    if (periph_rst) begin
      rst_hi <= rst_hi + 1;
      if (pipe_flush || pc_load || core_release) core_during_rst <= core_during_rst + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] rg, input logic [1:0] sz,
                       input logic [31:0] ad, input logic [31:0] dt);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_op = op; cmd_reg = rg; cmd_size = sz; cmd_addr = ad; cmd_data = dt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_ill = rsp_illegal; r_data = rsp_data;
  endtask

  initial begin
    int m0, f0;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 32'(busy), 0);
    chk("R9 reset periph_rst", 32'(periph_rst), 0);
    chk("R12 reset rsp", 32'(rsp_valid), 0);
    rst_n = 1'b1;

    m0 = mem_cnt; f0 = rf_cnt;
    issue(4'd0, 0, 0, 0, 0);
    chk("R1 nop status", 32'(r_ill), 0);
    chk("R1 nop data", r_data, 0);
    chk("R1 nop no activity", 32'(mem_cnt - m0 + rf_cnt - f0), 0);

    for (int i = 0; i < 16; i++) begin
      issue(4'd1, 4'(i), 0, 0, 0);
      chk("R2 reg read", r_data, 32'h1000_0000 + 32'(i) * 32'h111);
      issue(4'd2, 4'(i), 0, 0, 32'hC0DE_0000 + 32'(i));
      issue(4'd1, 4'(i), 0, 0, 0);
      chk("R2 reg write readback", r_data, 32'hC0DE_0000 + 32'(i));
    end
    for (int i = 0; i < 16; i += 5) begin
      issue(4'd3, 4'(i), 0, 0, 0);
      chk("R3 sys read", r_data, 32'h5000_0000 | 32'(i));
      issue(4'd4, 4'(i), 0, 0, 32'h7700_0000 + 32'(i));
      issue(4'd3, 4'(i), 0, 0, 0);
      chk("R3 sys write readback", r_data, 32'h7700_0000 + 32'(i));
      issue(4'd1, 4'(i), 0, 0, 0);
      chk("R3 data reg untouched", r_data, 32'hC0DE_0000 + 32'(i));
    end

    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 12; a += 3) begin
        dly = a % 4;
        issue(4'd5, 0, 2'(s), 32'(a), 0);
        chk("R4 read data", r_data, pat_word(a, s));
        chk("R4 read fc", 32'(last_fc), 5);
        chk("R4 read dir", 32'(last_we), 0);
      end

    for (int s = 0; s < 3; s++) begin
      issue(4'd6, 0, 2'(s), 32'h80 + 32'(8 * s), 32'h8765_4321);
      chk("R5 write fc", 32'(last_fc), 1);
      chk("R5 write size", 32'(last_size), 32'(s));
      issue(4'd5, 0, 2'(s), 32'h80 + 32'(8 * s), 0);
      chk("R5 write readback", r_data, 32'h8765_4321 & ((s == 2) ? 32'hFFFF_FFFF : ((32'd1 << (8 << s)) - 1)));
    end

    for (int s = 0; s < 3; s++) begin
      issue(4'd5, 0, 2'(s), 32'h20, 0);
      for (int k = 1; k <= 3; k++) begin
        issue(4'd7, 0, 2'd3, 32'hFFFF, 0);
        chk("R6 dump status", 32'(r_ill), 0);
        chk("R6 dump addr", last_addr, 32'h20 + 32'(k << s));
        chk("R6 dump data", r_data, pat_word(32'h20 + (k << s), s));
      end
    end

    issue(4'd6, 0, 2'd1, 32'hA0, 32'h1111);
    issue(4'd8, 0, 2'd0, 0, 32'h2222);
    chk("R7 fill addr", last_addr, 32'hA2);
    chk("R7 fill fc", 32'(last_fc), 1);
    issue(4'd8, 0, 2'd0, 0, 32'h3333);
    chk("R7 fill addr 2", last_addr, 32'hA4);
    issue(4'd5, 0, 2'd2, 32'hA0, 0);
    chk("R7 fill contents", r_data, 32'h1111_2222);
    issue(4'd5, 0, 2'd1, 32'hA4, 0);
    chk("R7 fill contents 2", r_data, 32'h3333);

    issue(4'd0, 0, 0, 0, 0);
    m0 = mem_cnt;
    issue(4'd7, 0, 0, 0, 0);
    chk("R8 dump after nop illegal", 32'(r_ill), 1);
    issue(4'd5, 0, 2'd0, 32'h4, 0);
    issue(4'd8, 0, 0, 0, 32'h99);
    chk("R8 fill after read illegal", 32'(r_ill), 1);
    issue(4'd6, 0, 2'd0, 32'h90, 32'h55);
    issue(4'd7, 0, 0, 0, 0);
    chk("R8 dump after write illegal", 32'(r_ill), 1);
    m0 = mem_cnt; f0 = rf_cnt;
    for (int op = 12; op < 16; op++) begin
      issue(4'(op), 0, 0, 0, 0);
      chk("R8 unassigned opcode", 32'(r_ill), 1);
    end
    issue(4'd5, 0, 2'd3, 32'h4, 0);
    chk("R8 bad size illegal", 32'(r_ill), 1);
    chk("R8 bad size data", r_data, 0);
    chk("R8 no cycles", 32'(mem_cnt - m0 + rf_cnt - f0), 0);

    rst_hi = 0;
    issue(4'd11, 0, 0, 0, 0);
    chk("R9 rst status", 32'(r_ill), 0);
    chk("R9 rst active", 32'(periph_rst), 1);
    m0 = mem_cnt; f0 = rf_cnt;
    issue(4'd0, 0, 0, 0, 0);
    chk("R8 nop during rst", 32'(r_ill), 1);
    issue(4'd9, 0, 0, 0, 0);
    chk("R8 go during rst", 32'(r_ill), 1);
    issue(4'd5, 0, 2'd0, 32'h4, 0);
    chk("R8 read during rst", 32'(r_ill), 1);
    chk("R8 no cycles during rst", 32'(mem_cnt - m0 + rf_cnt - f0), 0);
    while (periph_rst) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 rst length", 32'(rst_hi), 512);
    chk("R9 core untouched", 32'(core_during_rst), 0);
    issue(4'd0, 0, 0, 0, 0);
    chk("R9 accepted after rst", 32'(r_ill), 0);

    issue(4'd9, 0, 0, 0, 0);
    chk("R10 go status", 32'(r_ill), 0);
    @(negedge clk);
    chk("R10 release after flush", 32'(rel_cyc - flush_cyc), 1);
    chk("R10 no pc load", 32'(pcl_cnt), 0);

    issue(4'd10, 0, 0, 32'h0000_1234, 0);
    @(negedge clk);
    chk("R11 stack addr", last_addr, 32'hC0);
    chk("R11 stack data", last_wdata, 32'h0000_4242);
    chk("R11 stack fc", 32'(last_fc), 1);
    chk("R11 long write", {29'd0, last_we, last_size}, 32'h6);
    chk("R11 pc load", {pcl_val[30:0], 1'b0} | 32'(pcl_cnt == 1), 32'h2469);
    chk("R11 release", 32'(rel_cnt), 2);
    chk("R11 memory", {mem[8'hC0], mem[8'hC1], mem[8'hC2], mem[8'hC3]}, 32'h0000_4242);

    dly = 6;
    @(negedge clk);
    cmd_op = 4'd5; cmd_size = 2'd0; cmd_addr = 32'h8; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R12 busy in flight", 32'(busy), 1);
    cmd_op = 4'd2; cmd_reg = 4'd3; cmd_data = 32'hDEAD_BEEF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R12 first result", rsp_data, pat_word(8, 0));
    @(negedge clk);
    chk("R12 idle after rsp", 32'(busy), 0);
    dly = 0;
    issue(4'd1, 4'd3, 0, 0, 0);
    chk("R12 strobe while busy ignored", r_data, 32'hC0DE_0003);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule